// File: doc/BRIEF.md
# Serial Pattern-Unlock Access Sequencer

This block watches a memory-style bus one completed cycle at a time. Each cycle arrives as a single-clock strobe together with a read/write flag and the level of data bit 0. While the block is locked, every cycle is passed through to the memory array. A host unlocks it by writing a fixed 64-bit key, one bit per write cycle, on data bit 0. Any read cycle restarts the comparison from the first key bit. A wrong bit freezes the comparison until the next read.

Once all 64 key bits have matched, the block takes a snapshot of the 64-bit calendar image and diverts the next 64 bus cycles away from memory. A read cycle in this window drives the next snapshot bit onto data bit 0. A write cycle replaces that bit with the level on data bit 0. The bits run from bit 0 of register 0 to bit 7 of register 7. If any write happened in the window, the assembled image is handed back to the calendar with one load strobe. A reset input can abort the window, unless the captured image has its reset-ignore bit set.

The controller has four states. HUNT compares key bits. STALL is entered on a mismatch and left on a read. XFER is the 64-cycle transfer window. COMMIT issues the load strobe. The transitions are:
- HUNT to STALL on a mismatching write.
- STALL to HUNT on a read.
- HUNT to XFER on the 64th matching write.
- XFER to COMMIT after the 64th cycle when a write occurred.
- XFER to HUNT after a read-only window, or on an abort.
- COMMIT to HUNT after one clock. COMMIT handles bus cycles the same way HUNT does.

Top module: `unlock_seq`

## Requirements
- R1: After reset the block is in HUNT with the key pointer at 0. No strobe, load or data drive is active, and the first bus cycle is forwarded to memory.
- R2: The key is the 64-bit value 64'h5CA33AC5_5CA33AC5, presented least significant bit first on data bit 0. As bytes in order this is C5, 3A, A3, 5C, C5, 3A, A3, 5C.
- R3: A read cycle outside the transfer window returns the key pointer to bit 0, so a fresh full key is needed.
- R4: A write whose bit differs from the key bit at the pointer enters STALL. Every later write is then ignored, even if it carries correct key bits, until a read occurs.
- R5: Outside the transfer window, mem_pass is high in exactly the clock of each cycle strobe. This includes the key writes themselves.
- R6: In the clock of the 64th matching key write, cal_cap pulses and the calendar image is snapshotted. The next 64 cycles have mem_pass low.
- R7: In the window, the k-th cycle (k = 0..63) that is a read drives dq0_oe high and presents snapshot bit k on dq0_out. Bit k is bit k mod 8 of register k/8.
- R8: In the window, a write cycle stores data bit 0 into snapshot bit k. If at least one write occurred, cal_load is high for exactly one clock after the clock of the 64th cycle, with cal_wdata holding the updated image. A read-only window produces no load.
- R9: While hold_n_in is low at a clock edge in the window, the window is aborted if captured image bit 36 (register 4, bit 4) is 0. An abort gives no load, and the next cycle is forwarded to memory. If that bit is 1, hold_n_in has no effect.
- R10: After a window ends, either normally or by abort, the key pointer is at 0 and the key can be entered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_vld | input | 1 | One-clock strobe marking a completed bus cycle |
| cyc_wr | input | 1 | Cycle type: 1 write, 0 read |
| cyc_dq0 | input | 1 | Level of data bit 0 during the cycle |
| hold_n_in | input | 1 | Active-low transfer abort request |
| cal_img | input | 64 | Current calendar image |
| mem_pass | output | 1 | Cycle is forwarded to memory |
| dq0_out | output | 1 | Bit driven on data bit 0 for a window read |
| dq0_oe | output | 1 | Enable for dq0_out |
| cal_cap | output | 1 | Snapshot strobe toward the calendar |
| cal_load | output | 1 | Parallel load strobe toward the calendar |
| cal_wdata | output | 64 | Image to load |

## Verification
Directed sequences cover several cases:
- A clean key followed by an all-read window shows the snapshot order and that no load follows.
- A key followed by an all-write window shows the bit placement in the loaded image.
- A key with one corrupted bit, followed by the rest of the key, separates the frozen-pointer behaviour from a pointer that keeps advancing.
- A partial key broken by a read shows that the restart goes back to bit 0.

Abort is applied twice: once with the reset-ignore bit clear and once with it set, which separates an honoured abort from an ignored one. Seeded random mixes of good keys, corrupted keys, stray reads and mixed-direction windows are compared against a reference model in the bench.

// File: rtl/unlock_seq_pkg.sv
package unlock_seq_pkg;

    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_STALL  = 2'd1,
        ST_XFER   = 2'd2,
        ST_COMMIT = 2'd3
    } seq_state_t;

    // Serial key, bit 0 is sent first.
    localparam logic [63:0] UNLOCK_KEY = 64'h5CA3_3AC5_5CA3_3AC5;

endpackage

// File: rtl/unlock_key_matcher.sv
module unlock_key_matcher #(
    parameter int                  KEY_BITS = 64,
    parameter logic [KEY_BITS-1:0] KEY_PAT  = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ptr_clr,
    input  logic ptr_adv,
    input  logic din,
    output logic bit_ok,
    output logic at_last
);
    localparam int PW = (KEY_BITS > 1) ? $clog2(KEY_BITS) : 1;
    localparam logic [PW-1:0] LAST = PW'(KEY_BITS - 1);

    logic [PW-1:0] ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (ptr_clr) begin
            ptr_q <= '0;
        end else if (ptr_adv) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    assign bit_ok  = (din == KEY_PAT[ptr_q]);
    assign at_last = (ptr_q == LAST);

endmodule

// File: rtl/unlock_xfer_engine.sv
module unlock_xfer_engine #(
    parameter int IMG_BITS = 64,
    parameter int IGN_BIT  = 36
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                snap_ld,
    input  logic [IMG_BITS-1:0] img_in,
    input  logic                step,
    input  logic                step_wr,
    input  logic                din,
    input  logic                clear,
    output logic                dout,
    output logic                last,
    output logic                wrote_any,
    output logic                ign_rst,
    output logic [IMG_BITS-1:0] snap_o
);
    localparam int CW = (IMG_BITS > 1) ? $clog2(IMG_BITS) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(IMG_BITS - 1);

    logic [CW-1:0]       cnt_q;
    logic [IMG_BITS-1:0] snap_q;
    logic                wrote_q;
    logic                ign_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            snap_q  <= '0;
            wrote_q <= 1'b0;
            ign_q   <= 1'b0;
        end else if (snap_ld) begin
            cnt_q   <= '0;
            snap_q  <= img_in;
            wrote_q <= 1'b0;
            ign_q   <= img_in[IGN_BIT];
        end else if (clear) begin
            cnt_q   <= '0;
            wrote_q <= 1'b0;
        end else if (step) begin
            cnt_q <= (cnt_q == LAST_IDX) ? '0 : cnt_q + 1'b1;
            if (step_wr) begin
                snap_q[cnt_q] <= din;
                wrote_q       <= 1'b1;
            end
        end
    end

    assign dout      = snap_q[cnt_q];
    assign last      = (cnt_q == LAST_IDX);
    assign wrote_any = wrote_q | (step & step_wr);
    assign ign_rst   = ign_q;
    assign snap_o    = snap_q;

endmodule

// File: rtl/unlock_seq.sv
module unlock_seq
    import unlock_seq_pkg::*;
#(
    parameter int KEY_BITS = 64,
    parameter int IMG_BITS = 64,
    parameter int IGN_BIT  = 36
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cyc_vld,
    input  logic                cyc_wr,
    input  logic                cyc_dq0,
    input  logic                hold_n_in,
    input  logic [IMG_BITS-1:0] cal_img,
    output logic                mem_pass,
    output logic                dq0_out,
    output logic                dq0_oe,
    output logic                cal_cap,
    output logic                cal_load,
    output logic [IMG_BITS-1:0] cal_wdata
);
    function automatic logic [KEY_BITS-1:0] build_key();
        logic [KEY_BITS-1:0] k;
        for (int i = 0; i < KEY_BITS; i++) begin
            k[i] = UNLOCK_KEY[i % 64];
        end
        return k;
    endfunction

    localparam logic [KEY_BITS-1:0] KEY_PAT = build_key();

    seq_state_t state_q, state_d;

    logic rd_cyc, wr_cyc;
    logic bit_ok, at_last;
    logic ptr_clr, ptr_adv;
    logic cap_c, step_c, clr_c, abort_c;
    logic x_dout, x_last, x_wrote, x_ign;
    logic [IMG_BITS-1:0] x_snap;

    assign rd_cyc = cyc_vld & ~cyc_wr;
    assign wr_cyc = cyc_vld &  cyc_wr;

    unlock_key_matcher #(
        .KEY_BITS (KEY_BITS),
        .KEY_PAT  (KEY_PAT)
    ) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .ptr_clr (ptr_clr),
        .ptr_adv (ptr_adv),
        .din     (cyc_dq0),
        .bit_ok  (bit_ok),
        .at_last (at_last)
    );

    unlock_xfer_engine #(
        .IMG_BITS (IMG_BITS),
        .IGN_BIT  (IGN_BIT)
    ) u_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .snap_ld   (cap_c),
        .img_in    (cal_img),
        .step      (step_c),
        .step_wr   (cyc_wr),
        .din       (cyc_dq0),
        .clear     (clr_c),
        .dout      (x_dout),
        .last      (x_last),
        .wrote_any (x_wrote),
        .ign_rst   (x_ign),
        .snap_o    (x_snap)
    );

    assign abort_c = (state_q == ST_XFER) & ~x_ign & ~hold_n_in;

    // Next state and datapath controls.
    always_comb begin
        state_d = state_q;
        ptr_clr = 1'b0;
        ptr_adv = 1'b0;
        cap_c   = 1'b0;
        step_c  = 1'b0;
        clr_c   = 1'b0;
        unique case (state_q)
            ST_HUNT, ST_COMMIT: begin
                state_d = ST_HUNT;
                if (rd_cyc) begin
                    ptr_clr = 1'b1;
                end else if (wr_cyc) begin
                    if (!bit_ok) begin
                        state_d = ST_STALL;
                    end else if (at_last) begin
                        state_d = ST_XFER;
                        ptr_clr = 1'b1;
                        cap_c   = 1'b1;
                    end else begin
                        ptr_adv = 1'b1;
                    end
                end
            end
            ST_STALL: begin
                if (rd_cyc) begin
                    state_d = ST_HUNT;
                    ptr_clr = 1'b1;
                end
            end
            ST_XFER: begin
                if (abort_c) begin
                    state_d = ST_HUNT;
                    clr_c   = 1'b1;
                end else if (cyc_vld) begin
                    step_c = 1'b1;
                    if (x_last) begin
                        state_d = x_wrote ? ST_COMMIT : ST_HUNT;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // Port outputs.
    always_comb begin
        mem_pass  = cyc_vld & (state_q != ST_XFER);
        dq0_oe    = rd_cyc & (state_q == ST_XFER);
        dq0_out   = x_dout & dq0_oe;
        cal_cap   = cap_c;
        cal_load  = (state_q == ST_COMMIT);
        cal_wdata = x_snap;
    end

endmodule

// File: rtl/unlock_seq_chk.sv
module unlock_seq_chk #(
    parameter int IMG_BITS = 64
) (
    input logic clk,
    input logic rst_n,
    input logic cyc_vld,
    input logic cyc_wr,
    input logic mem_pass,
    input logic dq0_oe,
    input logic cal_cap,
    input logic cal_load
);
    localparam int BW = $clog2(IMG_BITS) + 2;

    logic [BW-1:0] blk_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_cnt <= '0;
        end else if (cal_cap) begin
            blk_cnt <= '0;
        end else if (cyc_vld && !mem_pass) begin
            blk_cnt <= blk_cnt + 1'b1;
        end
    end

    assert_pass_needs_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_pass |-> cyc_vld);

    assert_oe_only_window_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dq0_oe |-> (cyc_vld && !cyc_wr && !mem_pass));

    assert_cap_blocks_memory_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cal_cap |=> !mem_pass);

    assert_window_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        blk_cnt <= BW'(IMG_BITS));

    assert_load_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cal_load |=> !cal_load);

    assert_load_follows_window_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cal_load |-> $past(cyc_vld && !mem_pass));

    assert_cap_load_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cal_cap && cal_load));

endmodule

bind unlock_seq unlock_seq_chk #(.IMG_BITS(IMG_BITS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc_vld  (cyc_vld),
    .cyc_wr   (cyc_wr),
    .mem_pass (mem_pass),
    .dq0_oe   (dq0_oe),
    .cal_cap  (cal_cap),
    .cal_load (cal_load)
);

// File: tb/unlock_seq_bench.sv
`timescale 1ns/1ps
module unlock_seq_bench;
    localparam logic [63:0] KEY = 64'h5CA3_3AC5_5CA3_3AC5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_vld = 1'b0, cyc_wr = 1'b0, cyc_dq0 = 1'b0;
    logic        hold_n_in = 1'b1;
    logic [63:0] cal_img = '0;
    logic        mem_pass, dq0_out, dq0_oe, cal_cap, cal_load;
    logic [63:0] cal_wdata;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // Reference model state: 0 hunt, 1 window, 2 load pending.
    int          m_st = 0, m_ptr = 0, m_cnt = 0;
    bit          m_stall = 0, m_wrote = 0, m_ign = 0;
    logic [63:0] m_snap = '0;

    always #2.5 clk = ~clk;

    unlock_seq u_unlock_seq (
        .clk(clk), .rst_n(rst_n), .cyc_vld(cyc_vld), .cyc_wr(cyc_wr),
        .cyc_dq0(cyc_dq0), .hold_n_in(hold_n_in), .cal_img(cal_img),
        .mem_pass(mem_pass), .dq0_out(dq0_out), .dq0_oe(dq0_oe),
        .cal_cap(cal_cap), .cal_load(cal_load), .cal_wdata(cal_wdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_cap(input bit wr, input bit d);
        return (m_st != 1) && !m_stall && wr && (d == KEY[m_ptr]) && (m_ptr == 63);
    endfunction

    task automatic check_load();
        chk(cal_load == (m_st == 2), "R8 load strobe", 64'(cal_load), 64'(m_st == 2));
        if (m_st == 2) chk(cal_wdata == m_snap, "R8 loaded image", cal_wdata, m_snap);
    endtask

    task automatic cyc(input bit wr, input bit d);
        bit ecap;
        @(negedge clk);
        cyc_vld = 1'b1; cyc_wr = wr; cyc_dq0 = d;
        #1;
        ecap = exp_cap(wr, d);
        chk(mem_pass == (m_st != 1), (m_st == 1) ? "R6 memory inhibited" : "R5 memory forward",
            64'(mem_pass), 64'(m_st != 1));
        chk(cal_cap == ecap, "R6 capture strobe", 64'(cal_cap), 64'(ecap));
        chk(dq0_oe == (m_st == 1 && !wr), "R7 drive enable", 64'(dq0_oe), 64'(m_st == 1 && !wr));
        if (m_st == 1 && !wr)
            chk(dq0_out == m_snap[m_cnt], "R7 read bit", 64'(dq0_out), 64'(m_snap[m_cnt]));
        // model update
        if (m_st == 1) begin
            if (wr) begin m_snap[m_cnt] = d; m_wrote = 1; end
            if (m_cnt == 63) begin m_st = m_wrote ? 2 : 0; m_cnt = 0; end
            else m_cnt++;
        end else begin
            m_st = 0;
            if (m_stall) begin
                if (!wr) begin m_stall = 0; m_ptr = 0; end
            end else if (!wr) begin
                m_ptr = 0;
            end else if (d == KEY[m_ptr]) begin
                if (m_ptr == 63) begin
                    m_st = 1; m_ptr = 0; m_snap = cal_img; m_ign = cal_img[36];
                    m_cnt = 0; m_wrote = 0;
                end else m_ptr++;
            end else m_stall = 1;
        end
        @(posedge clk); #1;
        cyc_vld = 1'b0;
        check_load();
    endtask

    task automatic idle_clk(input bit hold);
        @(negedge clk);
        hold_n_in = hold;
        @(posedge clk); #1;
        hold_n_in = 1'b1;
        if (m_st == 1 && !hold && !m_ign) begin m_st = 0; m_cnt = 0; m_wrote = 0; end
        else if (m_st == 2) m_st = 0;
        chk(mem_pass == 1'b0, "R5 no cycle no forward", 64'(mem_pass), 64'd0);
        check_load();
    endtask

    task automatic send_key(input int bad_idx);
        for (int i = 0; i < 64; i++) cyc(1'b1, (i == bad_idx) ? ~KEY[i] : KEY[i]);
    endtask

    task automatic window(input int mode);
        for (int i = 0; i < 64; i++) begin
            bit wr = (mode == 0) ? 1'b0 : (mode == 1) ? 1'b1 : 1'($urandom_range(0, 1));
            cyc(wr, 1'($urandom_range(0, 1)));
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0251));
        repeat (3) @(posedge clk);
        #1;
        chk(mem_pass == 0 && cal_load == 0 && dq0_oe == 0 && cal_cap == 0, "R1 reset outputs",
            {cal_cap, dq0_oe, cal_load, mem_pass}, 64'd0);
        rst_n = 1'b1;
        idle_clk(1'b1);
        cyc(1'b1, 1'b0);          // R1 first cycle forwarded
        cyc(1'b0, 1'b0);

        // R2 R6 R7: clean key, read-only window, no load.
        cal_img = 64'h0123_4567_89AB_CDEF & ~(64'd1 << 36);
        send_key(-1);
        window(0);
        idle_clk(1'b1);
        // R8: write-only window, load expected.
        send_key(-1);
        window(1);
        idle_clk(1'b1);
        // R4: one bad bit freezes; the rest of the key is ignored.
        send_key(10);
        send_key(-1);
        cyc(1'b0, 1'b0);          // R3 read restarts
        send_key(-1);
        window(2);
        idle_clk(1'b1);
        // R3: partial key broken by read.
        for (int i = 0; i < 20; i++) cyc(1'b1, KEY[i]);
        cyc(1'b0, 1'b1);
        send_key(-1);
        window(2);
        // R9: abort honoured when ignore bit is clear.
        cal_img = 64'hFEDC_BA98_7654_3210 & ~(64'd1 << 36);
        send_key(-1);
        for (int i = 0; i < 5; i++) cyc(1'b1, 1'b1);
        idle_clk(1'b0);
        cyc(1'b1, 1'b0);          // forwarded again after abort
        cyc(1'b0, 1'b0);
        // R10: key accepted again after abort.
        // R9: abort ignored when ignore bit is set.
        cal_img = 64'h1111_2222_3333_4444 | (64'd1 << 36);
        send_key(-1);
        for (int i = 0; i < 7; i++) cyc(1'b1, 1'b0);
        idle_clk(1'b0);
        for (int i = 7; i < 64; i++) cyc(1'b0, 1'b0);
        idle_clk(1'b1);

        // Seeded random mixes.
        for (int it = 0; it < 150; it++) begin
            int sel = $urandom_range(0, 4);
            cal_img = {$urandom, $urandom};
            case (sel)
                0: begin cyc(1'b0, 1'b0); send_key(-1); window(2); end
                1: begin send_key($urandom_range(0, 63)); end
                2: begin
                    for (int i = 0; i < $urandom_range(1, 63); i++) cyc(1'b1, KEY[i]);
                    cyc(1'b0, 1'b0);
                end
                3: begin
                    cyc(1'b0, 1'b0); send_key(-1);
                    for (int i = 0; i < $urandom_range(0, 63); i++) cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
                    idle_clk(1'b0);
                end
                default: begin
                    for (int i = 0; i < 10; i++) cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
                end
            endcase
            if (m_st == 1) window(2);
            idle_clk(1'b1);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule